// File: doc/BRIEF.md
# Pixel Matrix Mode and Configuration Controller

This block is the digital control core of a pixel readout matrix arranged as columns of cells. Every cell stores one hit bit, one mask bit, one test-enable bit and a small delay-trim word. A two-bit mode select, a chip select and a read/write line decide what each clock does. The four modes are: event capture with column readout, capture qualified by a delayed trigger, serial loading of the delay-trim words, and serial loading of the mask and test-enable bits. A shared bidirectional bus carries one bit per column. In the serial modes that bit feeds the column's chain on writes and carries the bit leaving the chain on reads.

Hits arrive as per-cell coincidence pulses and are qualified by a strobe. A level-sensitive clear resets only the register group that the current mode select names, and this lets a system wipe one kind of state without disturbing the others. A fast-OR output, gated by an enable, summarises the unmasked hit lines. A test pulse is routed only to cells whose test-enable bit is set.

Top module: `pixmat_ctrl`

## Requirements
- R1: The bus is driven by the block only while chip select and read are both high and the mode select is 0, 2 or 3; bus bit c then carries the bit leaving column c's active chain. Otherwise the block leaves the bus released.
- R2: In mode 0 a cell's hit bit becomes 1 on a clock edge where strobe and that cell's hit line are both 1 and its mask bit is 0. Once set, it stays set until the cell is shifted or cleared.
- R3: In mode 0 with chip select and read high, every column shifts its hit bits one row toward the last row on each clock, a 0 enters row 0, and the last row's bit appears on the bus before the edge. A column is empty after as many reads as it has rows.
- R4: In mode 0 with chip select high and read low, only the columns whose bus bit is 1 are shifted as in R3, and the other columns keep capturing as in R2.
- R5: In mode 2 with chip select high, each column's delay-trim bits form one chain; cell r bit b sits at chain position r*3+b. A clock shifts every position up by one, the bus bit (on a write) enters position 0, and position rows*3-1 leaves.
- R6: In mode 3 with chip select high, each column's mask and test-enable bits form one chain; the mask of cell r sits at position 2r, its test-enable at 2r+1. Shifting and entry work as in R5, and position rows*2-1 leaves.
- R7: A read shifts a 0 into the chain, so reading back a full chain returns the previously loaded bits in order and leaves the chain empty.
- R8: While clear is high, mode select 0 zeroes all hit bits, 1 zeroes the trigger-latency pipeline and the pending hits, 2 zeroes all delay-trim bits, and 3 zeroes all mask and test-enable bits. The other groups keep their contents.
- R9: A cell with its mask bit set never sets its hit bit through capture and does not contribute to the fast-OR.
- R10: The test-pulse output of a cell equals the test-pulse input ANDed with that cell's test-enable bit.
- R11: The fast-OR output is the enable input ANDed with the OR of all unmasked hit lines.
- R12: In mode 1 a strobed, unmasked hit becomes pending. A strobe taken at clock edge k moves the pending hits into the hit bits at edge k+TRIG_LAT if the trigger is high there. Otherwise they are discarded at that edge.
- R13: With chip select low, or in mode 1, no chain shifts; delay-trim, mask and test-enable bits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Level-sensitive clear, acting on the group named by mode_sel |
| mode_sel | input | 2 | Mode select: 0 capture/readout, 1 triggered, 2 delay-trim chain, 3 mask/test chain |
| chip_sel | input | 1 | Qualifies bus accesses and shifting |
| rd_wr | input | 1 | 1 = read (block drives bus), 0 = write |
| bus_io | inout | NCOL | One bit per column, bidirectional |
| strobe | input | 1 | Hit qualification strobe |
| trig | input | 1 | Level-1 trigger for mode 1 |
| test_pulse | input | 1 | Test pulse to enabled cells |
| fast_or_en | input | 1 | Enable for the fast-OR output |
| hit_in | input | NCOL*NROW | Per-cell coincidence pulse, index c*NROW+r |
| test_out | output | NCOL*NROW | Per-cell gated test pulse, index c*NROW+r |
| fast_or | output | 1 | OR of unmasked hits, gated by enable |

## Verification
The bus value, the fast-OR and the test-pulse outputs are combinational on stored state. A change of state caused by inputs held over clock edge k is therefore visible on the ports in the following low phase. The bench drives inputs just after a falling edge and compares all three outputs against its model one time unit later, before the next rising edge. Triggered captures need the trigger exactly TRIG_LAT edges after the strobe edge, and the model counts those edges with its own latency array. Clears are pulsed in the low phase and applied to the model at once, so the next comparison already reflects them.

// File: rtl/pixmat_pkg.sv
package pixmat_pkg;

   typedef enum logic [1:0] {
      PM_EVT  = 2'd0,
      PM_TRIG = 2'd1,
      PM_DLY  = 2'd2,
      PM_MT   = 2'd3
   } pm_mode_e;

   // bits per cell in the mask/test chain and their positions
   localparam int unsigned MT_BITS     = 2;
   localparam int unsigned MT_MASK_POS = 0;
   localparam int unsigned MT_TEST_POS = 1;

endpackage

// File: rtl/pixmat_chain.sv
module pixmat_chain #(
   parameter int unsigned LEN = 8
) (
   input  logic           clk,
   input  logic           clr,
   input  logic           shift_en,
   input  logic           ser_in,
   output logic [LEN-1:0] q,
   output logic           ser_out
);

   if (LEN < 2) begin : g_len_chk
      $error("pixmat_chain: LEN must be at least 2");
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         q <= '0;
      end else if (shift_en) begin
         q <= {q[LEN-2:0], ser_in};
      end
   end

   assign ser_out = q[LEN-1];

endmodule

// File: rtl/pixmat_lat_pipe.sv
module pixmat_lat_pipe #(
   parameter int unsigned LAT = 4
) (
   input  logic clk,
   input  logic clr,
   input  logic din,
   output logic dout
);

   if (LAT < 1) begin : g_lat_chk
      $error("pixmat_lat_pipe: LAT must be at least 1");
   end

   if (LAT == 1) begin : g_single
      logic q;
      always_ff @(posedge clk or posedge clr) begin
         if (clr) q <= 1'b0;
         else     q <= din;
      end
      assign dout = q;
   end else begin : g_multi
      logic [LAT-1:0] sr;
      always_ff @(posedge clk or posedge clr) begin
         if (clr) sr <= '0;
         else     sr <= {sr[LAT-2:0], din};
      end
      assign dout = sr[LAT-1];
   end

endmodule

// File: rtl/pixmat_column.sv
module pixmat_column
   import pixmat_pkg::*;
#(
   parameter int unsigned NROW = 128,
   parameter int unsigned DLW  = 3
) (
   input  logic                clk,
   input  logic                clr_data,
   input  logic                clr_pend,
   input  logic                clr_dly,
   input  logic                clr_mt,
   input  pm_mode_e            mode,
   input  logic                shift_en,
   input  logic                cfg_in,
   input  logic                strobe,
   input  logic                emerge,
   input  logic                trig,
   input  logic                test_pulse,
   input  logic [NROW-1:0]     hit,
   output logic                col_out,
   output logic [NROW-1:0]     data_q,
   output logic [NROW-1:0]     mask_q,
   output logic [NROW-1:0]     test_out,
   output logic [NROW-1:0]     hit_live,
   output logic [NROW*DLW-1:0] dly_q
);

   localparam int unsigned DLEN = NROW * DLW;
   localparam int unsigned MLEN = NROW * MT_BITS;

   logic [MLEN-1:0] mt_q;
   logic [NROW-1:0] test_q;
   logic [NROW-1:0] cap;
   logic [NROW-1:0] pend_q;
   logic            dly_out;
   logic            mt_out;
   logic            fire;

   pixmat_chain #(.LEN(DLEN)) u_dly (
      .clk      (clk),
      .clr      (clr_dly),
      .shift_en (shift_en && (mode == PM_DLY)),
      .ser_in   (cfg_in),
      .q        (dly_q),
      .ser_out  (dly_out)
   );

   pixmat_chain #(.LEN(MLEN)) u_mt (
      .clk      (clk),
      .clr      (clr_mt),
      .shift_en (shift_en && (mode == PM_MT)),
      .ser_in   (cfg_in),
      .q        (mt_q),
      .ser_out  (mt_out)
   );

   for (genvar r = 0; r < NROW; r++) begin : g_cell
      assign mask_q[r] = mt_q[r*MT_BITS + MT_MASK_POS];
      assign test_q[r] = mt_q[r*MT_BITS + MT_TEST_POS];
   end

   assign hit_live = hit & ~mask_q;
   assign cap      = hit_live & {NROW{strobe}};
   assign test_out = test_q & {NROW{test_pulse}};
   assign fire     = (mode == PM_TRIG) && emerge && trig;

   // hit bits: shift (readout / column clocking), capture, or trigger transfer
   always_ff @(posedge clk or posedge clr_data) begin
      if (clr_data) begin
         data_q <= '0;
      end else if (mode == PM_EVT) begin
         if (shift_en) data_q <= {data_q[NROW-2:0], 1'b0};
         else          data_q <= data_q | cap;
      end else if (fire) begin
         data_q <= data_q | pend_q;
      end
   end

   // pending hits of the triggered mode, dropped when their window closes
   always_ff @(posedge clk or posedge clr_pend) begin
      if (clr_pend) begin
         pend_q <= '0;
      end else begin
         pend_q <= (emerge ? '0 : pend_q) | ((mode == PM_TRIG) ? cap : '0);
      end
   end

   always_comb begin
      unique case (mode)
         PM_EVT:  col_out = data_q[NROW-1];
         PM_DLY:  col_out = dly_out;
         PM_MT:   col_out = mt_out;
         default: col_out = 1'b0;
      endcase
   end

endmodule

// File: rtl/pixmat_ctrl.sv
module pixmat_ctrl
   import pixmat_pkg::*;
#(
   parameter int unsigned NCOL     = 16,
   parameter int unsigned NROW     = 128,
   parameter int unsigned DLW      = 3,
   parameter int unsigned TRIG_LAT = 4
) (
   input  logic                   clk,
   input  logic                   clr,
   input  logic [1:0]             mode_sel,
   input  logic                   chip_sel,
   input  logic                   rd_wr,
   inout  wire  [NCOL-1:0]        bus_io,
   input  logic                   strobe,
   input  logic                   trig,
   input  logic                   test_pulse,
   input  logic                   fast_or_en,
   input  logic [NCOL*NROW-1:0]   hit_in,
   output logic [NCOL*NROW-1:0]   test_out,
   output logic                   fast_or
);

   localparam int unsigned NCELL = NCOL * NROW;
   localparam int unsigned NDLY  = NCELL * DLW;

   if (NCOL < 1 || NCOL > 64) begin : g_ncol_chk
      $error("pixmat_ctrl: NCOL out of range");
   end
   if (NROW < 2) begin : g_nrow_chk
      $error("pixmat_ctrl: NROW must be at least 2");
   end
   if (DLW < 1) begin : g_dlw_chk
      $error("pixmat_ctrl: DLW must be at least 1");
   end
   if (TRIG_LAT < 1) begin : g_lat_chk
      $error("pixmat_ctrl: TRIG_LAT must be at least 1");
   end

   pm_mode_e          mode;
   logic              rd_acc;
   logic              wr_acc;
   logic              bus_oe;
   logic              clr_data;
   logic              clr_pend;
   logic              clr_dly;
   logic              clr_mt;
   logic              emerge;
   logic [NCOL-1:0]   col_out;
   logic [NCOL-1:0]   col_shift;
   logic [NCELL-1:0]  data_all;
   logic [NCELL-1:0]  mask_all;
   logic [NCELL-1:0]  hit_live_all;
   logic [NDLY-1:0]   dly_all;
   logic              data_shift_any;

   assign mode   = pm_mode_e'(mode_sel);
   assign rd_acc = chip_sel && rd_wr;
   assign wr_acc = chip_sel && !rd_wr;
   assign bus_oe = rd_acc && (mode != PM_TRIG);
   assign bus_io = bus_oe ? col_out : {NCOL{1'bz}};

   // clear targets chosen by the mode select
   assign clr_data = clr && (mode == PM_EVT);
   assign clr_pend = clr && (mode == PM_TRIG);
   assign clr_dly  = clr && (mode == PM_DLY);
   assign clr_mt   = clr && (mode == PM_MT);

   pixmat_lat_pipe #(.LAT(TRIG_LAT)) u_lat (
      .clk  (clk),
      .clr  (clr_pend),
      .din  (strobe && (mode == PM_TRIG)),
      .dout (emerge)
   );

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      logic sh;
      logic cin;

      assign sh  = (mode == PM_EVT) ? (rd_acc || (wr_acc && bus_io[c])) :
                   ((mode == PM_DLY) || (mode == PM_MT)) ? chip_sel : 1'b0;
      assign cin = wr_acc && bus_io[c];
      assign col_shift[c] = sh;

      pixmat_column #(.NROW(NROW), .DLW(DLW)) u_col (
         .clk        (clk),
         .clr_data   (clr_data),
         .clr_pend   (clr_pend),
         .clr_dly    (clr_dly),
         .clr_mt     (clr_mt),
         .mode       (mode),
         .shift_en   (sh),
         .cfg_in     (cin),
         .strobe     (strobe),
         .emerge     (emerge),
         .trig       (trig),
         .test_pulse (test_pulse),
         .hit        (hit_in[c*NROW +: NROW]),
         .col_out    (col_out[c]),
         .data_q     (data_all[c*NROW +: NROW]),
         .mask_q     (mask_all[c*NROW +: NROW]),
         .test_out   (test_out[c*NROW +: NROW]),
         .hit_live   (hit_live_all[c*NROW +: NROW]),
         .dly_q      (dly_all[c*NROW*DLW +: NROW*DLW])
      );
   end

   assign data_shift_any = (mode == PM_EVT) && (|col_shift);
   assign fast_or        = fast_or_en && (|hit_live_all);

endmodule

// File: rtl/pixmat_ctrl_chk.sv
module pixmat_ctrl_chk #(
   parameter int unsigned NCOL = 16,
   parameter int unsigned NROW = 128,
   parameter int unsigned DLW  = 3
) (
   input logic                      clk,
   input logic                      clr,
   input logic [1:0]                mode_sel,
   input logic                      chip_sel,
   input logic                      rd_wr,
   input logic                      trig,
   input logic                      test_pulse,
   input logic                      fast_or_en,
   input logic                      fast_or,
   input logic [NCOL*NROW-1:0]      test_out,
   input logic [NCOL*NROW-1:0]      data_all,
   input logic [NCOL*NROW-1:0]      mask_all,
   input logic [NCOL*NROW*DLW-1:0]  dly_all,
   input logic                      data_shift_any
);

   // remembers a clear pulse that fell between two edges
   logic clr_q;
   always_ff @(posedge clk or posedge clr) begin
      if (clr) clr_q <= 1'b1;
      else     clr_q <= 1'b0;
   end

   logic [NCOL-1:0] row0;
   for (genvar c = 0; c < NCOL; c++) begin : g_row0
      assign row0[c] = data_all[c*NROW];
   end

   assert_mask_blocks_capture_R9: assert property (@(posedge clk) disable iff (clr || clr_q)
      !$past(data_shift_any) |-> ((data_all & ~$past(data_all) & $past(mask_all)) == '0));

   assert_fastor_needs_enable_R11: assert property (@(posedge clk) disable iff (clr || clr_q)
      fast_or |-> fast_or_en);

   assert_test_needs_pulse_R10: assert property (@(posedge clk) disable iff (clr || clr_q)
      (|test_out) |-> test_pulse);

   assert_read_fills_zero_R3: assert property (@(posedge clk) disable iff (clr || clr_q)
      $past(chip_sel && rd_wr && (mode_sel == 2'd0)) |-> (row0 == '0));

   assert_trig_gates_data_R12: assert property (@(posedge clk) disable iff (clr || clr_q)
      (($past(mode_sel) == 2'd1) && !$past(trig)) |-> ((data_all & ~$past(data_all)) == '0));

   assert_dly_hold_R13: assert property (@(posedge clk) disable iff (clr || clr_q)
      !$past(chip_sel && (mode_sel == 2'd2)) |-> $stable(dly_all));

   assert_mask_hold_R13: assert property (@(posedge clk) disable iff (clr || clr_q)
      !$past(chip_sel && (mode_sel == 2'd3)) |-> $stable(mask_all));

endmodule

bind pixmat_ctrl pixmat_ctrl_chk #(.NCOL(NCOL), .NROW(NROW), .DLW(DLW)) u_chk (
   .clk            (clk),
   .clr            (clr),
   .mode_sel       (mode_sel),
   .chip_sel       (chip_sel),
   .rd_wr          (rd_wr),
   .trig           (trig),
   .test_pulse     (test_pulse),
   .fast_or_en     (fast_or_en),
   .fast_or        (fast_or),
   .test_out       (test_out),
   .data_all       (data_all),
   .mask_all       (mask_all),
   .dly_all        (dly_all),
   .data_shift_any (data_shift_any)
);

// File: tb/pixmat_ctrl_bench.sv
module pixmat_ctrl_bench;

   localparam int NC  = 16;
   localparam int NR  = 128;
   localparam int DL  = 3;
   localparam int LAT = 4;

   logic              clk;
   logic              clr;
   logic [1:0]        mode_sel;
   logic              chip_sel;
   logic              rd_wr;
   logic              strobe;
   logic              trig;
   logic              test_pulse;
   logic              fast_or_en;
   logic [NC*NR-1:0]  hit_in;
   logic [NC*NR-1:0]  test_out;
   logic              fast_or;
   wire  [NC-1:0]     bus_io;
   logic [NC-1:0]     drv;
   logic              drv_en;

   assign bus_io = drv_en ? drv : {NC{1'bz}};

   pixmat_ctrl #(.NCOL(NC), .NROW(NR), .DLW(DL), .TRIG_LAT(LAT)) u_pixmat_ctrl (
      .clk        (clk),
      .clr        (clr),
      .mode_sel   (mode_sel),
      .chip_sel   (chip_sel),
      .rd_wr      (rd_wr),
      .bus_io     (bus_io),
      .strobe     (strobe),
      .trig       (trig),
      .test_pulse (test_pulse),
      .fast_or_en (fast_or_en),
      .hit_in     (hit_in),
      .test_out   (test_out),
      .fast_or    (fast_or)
   );

   // reference state
   bit m_data [NC][NR];
   bit m_pend [NC][NR];
   bit m_dly  [NC][NR*DL];
   bit m_mt   [NC][NR*2];
   bit m_lat  [LAT];

   int    n_chk;
   int    n_fail;
   string req;

   initial begin
      clk = 1'b0;
      #20;
      forever #5 clk = ~clk;
   end

   function automatic bit pat(int c, int k, int s);
      return ((c*5 + k*3 + s*7) % 11) < 4;
   endfunction

   task automatic compare();
      logic [NC-1:0]    eb;
      logic [NC*NR-1:0] et;
      logic             ef;
      ef = 1'b0;
      for (int c = 0; c < NC; c++) begin
         for (int r = 0; r < NR; r++) begin
            et[c*NR+r] = test_pulse & m_mt[c][2*r+1];
            if (hit_in[c*NR+r] && !m_mt[c][2*r]) ef = 1'b1;
         end
      end
      ef = ef & fast_or_en;
      if (chip_sel && rd_wr && mode_sel != 2'd1) begin
         for (int c = 0; c < NC; c++) begin
            case (mode_sel)
               2'd0:    eb[c] = m_data[c][NR-1];
               2'd2:    eb[c] = m_dly[c][NR*DL-1];
               default: eb[c] = m_mt[c][NR*2-1];
            endcase
         end
      end else if (drv_en) begin
         eb = drv;
      end else begin
         eb = {NC{1'bz}};
      end
      n_chk++;
      if (bus_io !== eb) begin
         n_fail++;
         $display("FAIL %s bus: got %h expected %h at %0t", req, bus_io, eb, $time);
      end
      n_chk++;
      if (test_out !== et) begin
         n_fail++;
         $display("FAIL %s test_out: got %h expected %h", req, test_out, et);
      end
      n_chk++;
      if (fast_or !== ef) begin
         n_fail++;
         $display("FAIL %s fast_or: got %b expected %b", req, fast_or, ef);
      end
   endtask

   task automatic model_edge();
      bit emerge;
      bit rd;
      bit wr;
      bit sh;
      bit si;
      bit cap;
      emerge = m_lat[LAT-1];
      rd = chip_sel && rd_wr;
      wr = chip_sel && !rd_wr;
      for (int c = 0; c < NC; c++) begin
         si = wr && drv[c];
         case (mode_sel)
            2'd0:    sh = rd || (wr && drv[c]);
            2'd1:    sh = 1'b0;
            default: sh = chip_sel;
         endcase
         if (mode_sel == 2'd0) begin
            if (sh) begin
               for (int r = NR-1; r > 0; r--) m_data[c][r] = m_data[c][r-1];
               m_data[c][0] = 1'b0;
            end else begin
               for (int r = 0; r < NR; r++)
                  if (strobe && hit_in[c*NR+r] && !m_mt[c][2*r]) m_data[c][r] = 1'b1;
            end
         end else if (mode_sel == 2'd1 && emerge && trig) begin
            for (int r = 0; r < NR; r++) if (m_pend[c][r]) m_data[c][r] = 1'b1;
         end
         for (int r = 0; r < NR; r++) begin
            cap = (mode_sel == 2'd1) && strobe && hit_in[c*NR+r] && !m_mt[c][2*r];
            m_pend[c][r] = (emerge ? 1'b0 : m_pend[c][r]) | cap;
         end
         if (mode_sel == 2'd2 && sh) begin
            for (int p = NR*DL-1; p > 0; p--) m_dly[c][p] = m_dly[c][p-1];
            m_dly[c][0] = si;
         end
         if (mode_sel == 2'd3 && sh) begin
            for (int p = NR*2-1; p > 0; p--) m_mt[c][p] = m_mt[c][p-1];
            m_mt[c][0] = si;
         end
      end
      for (int i = LAT-1; i > 0; i--) m_lat[i] = m_lat[i-1];
      m_lat[0] = strobe && (mode_sel == 2'd1);
   endtask

   // called just after a falling edge
   task automatic cyc(logic [1:0] md, logic cs, logic rd, logic [NC-1:0] bv,
                      logic stb, logic trg, logic tp, logic foe);
      mode_sel   = md;
      chip_sel   = cs;
      rd_wr      = rd;
      drv        = bv;
      drv_en     = cs && !rd;
      strobe     = stb;
      trig       = trg;
      test_pulse = tp;
      fast_or_en = foe;
      #1;
      compare();
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic do_clr(logic [1:0] md);
      mode_sel = md;
      chip_sel = 1'b0;
      drv_en   = 1'b0;
      #1 clr = 1'b1;
      #1 clr = 1'b0;
      for (int c = 0; c < NC; c++) begin
         case (md)
            2'd0: for (int r = 0; r < NR; r++) m_data[c][r] = 1'b0;
            2'd1: for (int r = 0; r < NR; r++) m_pend[c][r] = 1'b0;
            2'd2: for (int p = 0; p < NR*DL; p++) m_dly[c][p] = 1'b0;
            default: for (int p = 0; p < NR*2; p++) m_mt[c][p] = 1'b0;
         endcase
      end
      if (md == 2'd1) for (int i = 0; i < LAT; i++) m_lat[i] = 1'b0;
   endtask

   task automatic load(logic [1:0] md, int len, int seed);
      logic [NC-1:0] bv;
      for (int k = 0; k < len; k++) begin
         for (int c = 0; c < NC; c++) bv[c] = pat(c, k, seed);
         cyc(md, 1'b1, 1'b0, bv, 1'b0, 1'b0, 1'b0, 1'b0);
      end
   endtask

   task automatic rd_n(logic [1:0] md, int len);
      for (int k = 0; k < len; k++)
         cyc(md, 1'b1, 1'b1, '0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic set_hits(int s);
      for (int i = 0; i < NC*NR; i++) hit_in[i] = ((i*7 + s) % 5) == 0;
   endtask

   initial begin
      n_chk = 0; n_fail = 0; req = "R8";
      clr = 1'b0; mode_sel = 2'd0; chip_sel = 1'b0; rd_wr = 1'b0;
      strobe = 1'b0; trig = 1'b0; test_pulse = 1'b0; fast_or_en = 1'b0;
      hit_in = '0; drv = '0; drv_en = 1'b0;
      for (int m = 0; m < 4; m++) do_clr(m[1:0]);
      @(negedge clk);

      // R8: everything clear after the group clears
      rd_n(2'd0, 3); rd_n(2'd2, 3); rd_n(2'd3, 3);

      // R6 / R7: mask-test chain load and destructive readback
      req = "R6"; load(2'd3, NR*2, 1);
      req = "R7"; rd_n(2'd3, NR*2);
      req = "R6"; load(2'd3, NR*2, 2);

      // R5 / R13: delay chain, then idle cycles that must not disturb it
      req = "R5"; load(2'd2, NR*DL, 3);
      req = "R13";
      for (int k = 0; k < 4; k++) cyc(2'd2, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 4; k++) cyc(2'd1, 1'b1, 1'b0, 16'hA5A5, 1'b0, 1'b0, 1'b0, 1'b0);
      req = "R7"; rd_n(2'd2, NR*DL);

      // R1: bus released without a qualified read
      req = "R1";
      cyc(2'd0, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc(2'd1, 1'b1, 1'b1, '0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R10: test pulse routing
      req = "R10";
      cyc(2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
      cyc(2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R2 / R9 / R11: capture and fast-OR
      req = "R11"; set_hits(0);
      cyc(2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc(2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
      req = "R2";
      cyc(2'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
      set_hits(2);
      req = "R9";
      cyc(2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
      hit_in = '0;

      // R4: column clocking on a write
      req = "R4";
      cyc(2'd0, 1'b1, 1'b0, 16'h00F0, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc(2'd0, 1'b1, 1'b0, 16'h0300, 1'b0, 1'b0, 1'b0, 1'b0);

      // R3: readout empties the columns
      req = "R3"; rd_n(2'd0, NR + 2);

      // R12: triggered capture, one kept and one discarded
      req = "R12"; set_hits(1);
      cyc(2'd1, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
      hit_in = '0;
      for (int k = 1; k < LAT; k++) cyc(2'd1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc(2'd1, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
      set_hits(3);
      cyc(2'd1, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
      hit_in = '0;
      for (int k = 0; k < LAT; k++) cyc(2'd1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc(2'd1, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
      rd_n(2'd0, NR);

      // R8: group clears leave other groups intact
      req = "R8"; set_hits(4);
      cyc(2'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1);
      hit_in = '0;
      do_clr(2'd2);
      rd_n(2'd0, 4);
      do_clr(2'd0);
      rd_n(2'd0, 4);
      do_clr(2'd3);
      cyc(2'd0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
      rd_n(2'd3, 8);
      do_clr(2'd1);
      rd_n(2'd2, 8);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule